// File: doc/BRIEF.md
# Card Controller Interrupt Flag Unit

This unit sits beside a memory-card host controller. It turns the controller's event pulses into sticky interrupt flags, and it drives one interrupt request line to the processor. The flags live in one status byte, and a mask byte decides which flags may raise the request.

The events have three sources:
- **Card-detect level.** It is synchronised by two flops and then watched for a change in either direction.
- **Transfer engine.** It supplies four end-of-phase pulses: response, command, frame and block.
- **FIFO.** Two fill thresholds are derived from the FIFO occupancy count. In receive they use the bytes waiting to be read, and in transmit they use the free space.

Software reaches the unit over a small register bus. It has a read strobe, a write strobe, an address and a write data byte. Read data is combinational from the address.
- Address 0 is the status byte. Reading it clears every flag.
- Address 1 is the mask byte.

The bus has no valid/ready handshake: every strobe is taken in the cycle it is high, and the unit never stalls. The other pins are plain levels or single-cycle pulses.

Top module: `cardirq_flags`

## Requirements
- R1: After reset the status byte reads 0x00, the mask byte reads 0x00 and `irq_o` is low.
- R2: A one-cycle pulse sets its flag at the next rising edge, and the flag stays set until the status byte is read. The status bit positions are:
  - bit 6: end-of-response.
  - bit 5: end-of-command.
  - bit 4: end-of-frame.
  - bit 1: end-of-block.
- R3: Bit 0 of the status byte and bit 0 of the mask byte always read 0.
- R4: A read strobe at address 0 returns the current flags and clears all of them at that edge. A write to address 0 changes nothing.
- R5: Each change of `card_det_i`, rising or falling, sets status bit 7. After two synchroniser flops the flag is visible by the third rising edge, and a steady level sets nothing further.
- R6: The FIFO thresholds use bytes available: `fifo_level_i` in receive (`dir_tx_i`=0), or 16 minus `fifo_level_i` in transmit (`dir_tx_i`=1).
  - Bit 2 (half) sets when the bytes available rise from below 8 to 8 or more.
  - Bit 3 (whole) sets when the bytes available rise from below 16 to 16.
  - Neither bit sets again while the level stays at or above its threshold.
- R7: A write at address 1 loads the mask byte, and a read at address 1 returns it. A mask bit at 1 keeps its flag from raising `irq_o`, but the flag still sets and still reads back.
- R8: `irq_o` is high exactly when some status bit is 1 while its mask bit is 0.
- R9: An event in the same cycle as a status read leaves its flag set after the read. That read need not show the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_det_i | input | 1 | Asynchronous card-present level |
| resp_done_i | input | 1 | End-of-response pulse |
| cmd_done_i | input | 1 | End-of-command pulse |
| frame_done_i | input | 1 | End-of-frame pulse (any transfer type) |
| block_done_i | input | 1 | End-of-block pulse (block transfers only) |
| fifo_level_i | input | 5 | FIFO occupancy in bytes, 0 to 16 |
| dir_tx_i | input | 1 | 1 = transmit, 0 = receive |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 = status, 1 = mask |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after three corner cases:
- **Event during a read.** A pulse that lands in the same cycle as a status read would be lost by a design that clears after merging the new events.
- **FIFO thresholds.** A level held above a threshold would keep re-arming the flag if the design used a level compare instead of an upward crossing. A direction flip that inverts the free-space sense would go unflagged if the design used the raw count.
- **Card-detect edges and masking.** Both edges of the card-detect level are driven, so a design that detects only one edge misses the falling edge. Masked flags are checked for staying visible without raising the request, and writes to the read-only status byte are checked for having no effect.

// File: rtl/cardirq_pkg.sv
`timescale 1ns/1ps
package cardirq_pkg;
  localparam int FLAG_W    = 8;
  localparam int B_CDET    = 7;
  localparam int B_RESP    = 6;
  localparam int B_CMD     = 5;
  localparam int B_FRAME   = 4;
  localparam int B_WHOLE   = 3;
  localparam int B_HALF    = 2;
  localparam int B_BLOCK   = 1;
  localparam logic [FLAG_W-1:0] LIVE_BITS = 8'hFE;
endpackage

// File: rtl/cardirq_sync_edge.sv
`timescale 1ns/1ps
module cardirq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic change_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], level_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign change_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/cardirq_fifo_thresh.sv
`timescale 1ns/1ps
module cardirq_fifo_thresh #(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic             dir_tx_i,
  output logic             cross_o
);
  localparam logic [LVL_W-1:0] DEPTH_V  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] THRESH_V = LVL_W'(THRESH);

  logic [LVL_W-1:0] avail;
  logic             above_now;
  logic             above_q;

  assign avail     = dir_tx_i ? (DEPTH_V - level_i) : level_i;
  assign above_now = (avail >= THRESH_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= above_now;
  end

  assign cross_o = above_now & ~above_q;
endmodule

// File: rtl/cardirq_flag_bank.sv
`timescale 1ns/1ps
module cardirq_flag_bank
  import cardirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              clear_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] kept;

  assign kept = clear_i ? '0 : flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (kept | set_i) & LIVE_BITS;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/cardirq_flags.sv
`timescale 1ns/1ps
module cardirq_flags
  import cardirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 1,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_det_i,
  input  logic              resp_done_i,
  input  logic              cmd_done_i,
  input  logic              frame_done_i,
  input  logic              block_done_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              dir_tx_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [FLAG_W-1:0] bus_wdata_i,
  output logic [FLAG_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int N_THR = 2;
  localparam int THR_LEVEL [N_THR] = '{FIFO_DEPTH / 2, FIFO_DEPTH};
  localparam int THR_BIT   [N_THR] = '{B_HALF, B_WHOLE};
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(1);

  logic              cdet_chg;
  logic [N_THR-1:0]  thr_hit;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] mask_q;
  logic              sel_status;
  logic              sel_mask;

  assign sel_status = (bus_addr_i == A_STATUS);
  assign sel_mask   = (bus_addr_i == A_MASK);

  cardirq_sync_edge #(.STAGES(2)) u_cdet (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (card_det_i),
    .change_o (cdet_chg)
  );

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    cardirq_fifo_thresh #(
      .DEPTH  (FIFO_DEPTH),
      .THRESH (THR_LEVEL[t]),
      .LVL_W  (LVL_W)
    ) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  (fifo_level_i),
      .dir_tx_i (dir_tx_i),
      .cross_o  (thr_hit[t])
    );
  end

  always_comb begin
    set_vec           = '0;
    set_vec[B_CDET]   = cdet_chg;
    set_vec[B_RESP]   = resp_done_i;
    set_vec[B_CMD]    = cmd_done_i;
    set_vec[B_FRAME]  = frame_done_i;
    set_vec[B_BLOCK]  = block_done_i;
    for (int t = 0; t < N_THR; t++) set_vec[THR_BIT[t]] = thr_hit[t];
  end

  cardirq_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clear_i (bus_rd_i & sel_status),
    .flags_o (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    mask_q <= '0;
    else if (bus_wr_i && sel_mask) mask_q <= bus_wdata_i & LIVE_BITS;
  end

  assign bus_rdata_o = sel_mask ? mask_q : (sel_status ? flags : '0);
  assign irq_o       = |(flags & ~mask_q);
endmodule

// File: rtl/cardirq_flags_chk.sv
`timescale 1ns/1ps
module cardirq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd_i,
  input logic       bus_wr_i,
  input logic [0:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] bus_rdata_o,
  input logic       irq_o,
  input logic [7:0] flags,
  input logic [7:0] mask_q,
  input logic [7:0] set_vec
);
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[0] == 1'b0); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 1'b0 && set_vec == 8'h00) |=> (flags == 8'h00)); // R4

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 8'h00) |=> ((flags & $past(set_vec & 8'hFE)) == $past(set_vec & 8'hFE))); // R9

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_i && bus_addr_i == 1'b0) |=> ((flags & $past(flags)) == $past(flags))); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 1'b1) |=> (mask_q == ($past(bus_wdata_i) & 8'hFE))); // R7

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'hFE) |-> !irq_o); // R7

  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 8'h00) |-> !irq_o); // R8
endmodule

bind cardirq_flags cardirq_flags_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .flags       (flags),
  .mask_q      (mask_q),
  .set_vec     (set_vec)
);

// File: tb/cardirq_flags_bench.sv
`timescale 1ns/1ps
module cardirq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card_det_i = 1'b0;
  logic       resp_done_i = 1'b0, cmd_done_i = 1'b0;
  logic       frame_done_i = 1'b0, block_done_i = 1'b0;
  logic [4:0] fifo_level_i = '0;
  logic       dir_tx_i = 1'b0;
  logic       bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [0:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cardirq_flags u_cardirq_flags (
    .clk(clk), .rst_n(rst_n), .card_det_i(card_det_i),
    .resp_done_i(resp_done_i), .cmd_done_i(cmd_done_i),
    .frame_done_i(frame_done_i), .block_done_i(block_done_i),
    .fifo_level_i(fifo_level_i), .dir_tx_i(dir_tx_i),
    .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  // {mask[7:0], events {resp,cmd,frame,block}, expected status, expected irq}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 4'b1000, 8'h40, 1'b1},
    {8'h00, 4'b0100, 8'h20, 1'b1},
    {8'h00, 4'b0010, 8'h10, 1'b1},
    {8'h00, 4'b0001, 8'h02, 1'b1},
    {8'h40, 4'b1000, 8'h40, 1'b0},
    {8'h40, 4'b1100, 8'h60, 1'b1},
    {8'h72, 4'b1111, 8'h72, 1'b0},
    {8'hFF, 4'b0011, 8'h12, 1'b0}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 v = bus_rdata_o;
    cyc(); bus_rd_i = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    cyc(); bus_wr_i = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    {resp_done_i, cmd_done_i, frame_done_i, block_done_i} = ev;
    cyc();
    {resp_done_i, cmd_done_i, frame_done_i, block_done_i} = 4'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    cyc(3); rst_n = 1'b1; cyc();

    // R1 reset state
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    rd(1'b1, v); check("R1 mask", v, 8'h00);
    rd(1'b0, v); check("R1 status", v, 8'h00);

    // R2 R7 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, VEC[i][20:13]);
      pulse(VEC[i][12:9]);
      check("R8 irq", {7'b0, irq_o}, {7'b0, VEC[i][0]});
      rd(1'b0, v); check("R2 R7 status", v, VEC[i][8:1]);
      check("R8 irq after clear", {7'b0, irq_o}, 8'h00);
    end

    // R3 mask bit 0 reads zero
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R3 mask", v, 8'hFE);
    wr(1'b1, 8'h00);

    // R4 write to status has no effect; second read empty
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check("R4 write ignored", v, 8'h00);
    pulse(4'b0010);
    rd(1'b0, v); check("R4 first read", v, 8'h10);
    rd(1'b0, v); check("R4 second read", v, 8'h00);

    // R9 event during read
    pulse(4'b0001);
    bus_addr_i = 1'b0; bus_rd_i = 1'b1; resp_done_i = 1'b1;
    #1 v = bus_rdata_o;
    cyc(); bus_rd_i = 1'b0; resp_done_i = 1'b0;
    check("R9 read value", v, 8'h02);
    rd(1'b0, v); check("R9 kept event", v, 8'h40);

    // R5 card-detect both edges
    card_det_i = 1'b1; cyc(4);
    check("R5 irq rise", {7'b0, irq_o}, 8'h01);
    rd(1'b0, v); check("R5 rise", v, 8'h80);
    cyc(4);
    rd(1'b0, v); check("R5 steady", v, 8'h00);
    card_det_i = 1'b0; cyc(4);
    rd(1'b0, v); check("R5 fall", v, 8'h80);

    // R6 receive thresholds
    fifo_level_i = 5'd7; cyc(2);
    rd(1'b0, v); check("R6 rx 7", v, 8'h00);
    fifo_level_i = 5'd8; cyc(2);
    rd(1'b0, v); check("R6 rx 8 half", v, 8'h04);
    cyc(3);
    rd(1'b0, v); check("R6 rx hold no reset", v, 8'h00);
    fifo_level_i = 5'd16; cyc(2);
    rd(1'b0, v); check("R6 rx 16 whole", v, 8'h08);
    fifo_level_i = 5'd0; cyc(2);
    rd(1'b0, v); check("R6 rx drain", v, 8'h00);
    // R6 transmit: free space = 16 - level
    dir_tx_i = 1'b1; cyc(2);
    rd(1'b0, v); check("R6 tx empty", v, 8'h0C);
    fifo_level_i = 5'd12; cyc(2);
    rd(1'b0, v); check("R6 tx 4 free", v, 8'h00);
    fifo_level_i = 5'd8; cyc(2);
    rd(1'b0, v); check("R6 tx 8 free", v, 8'h04);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule